// File: doc/BRIEF.md
# Multi-Style Host Bus Slave

This block lets an external host processor read and write an internal space of 32-bit words over a 16-bit parallel bus. A 3-bit mode strap chooses one of two bus styles. The first is a strobe-qualified style: an active-low strobe and a read/write level. The second is a split-enable style with separate active-low read and write enables. The block has an active-high wait output with its own output enable, a pin-selected byte-order reversal and an interrupt output that is always driven. Inside the chip it issues requests to a memory port that answers after a variable number of cycles.

All host control lines pass through two-flop synchronisers into the core clock. An access starts on the synchronised assertion of the qualifying strobe. Each 32-bit word moves as two 16-bit halves, chosen by a half select input. Half 0 goes first. A half-0 read fetches the whole word and latches it, and a half-1 read is served from that latch. A half-0 write only stages its data, and a half-1 write commits the full word.

The controller has five states. ST_IDLE waits for a start. It goes to ST_FETCH on a half-0 read, to ST_SERVE on a half-1 read, to ST_HOLD on a half-0 write and to ST_WRITE on a half-1 write. ST_FETCH keeps the memory request up until acknowledge, then goes to ST_SERVE. ST_WRITE keeps the write request up until acknowledge, then goes to ST_HOLD. ST_SERVE drives the data bus until the synchronised strobe is released, then returns to ST_IDLE. ST_HOLD waits for that release and then returns to ST_IDLE.

Top module: `hbus_slave`

## Requirements
- R1: Mode 3'b000 selects the strobe style with wait, 3'b001 the strobe style without wait, and 3'b010 the split-enable style. Any other mode value ignores every access: no memory request is made and the data bus is not driven.
- R2: In strobe style an access is qualified only while both hst_strb_n and hst_cs_io_n are low. hst_rnw=1 reads and hst_rnw=0 writes. hst_cs_mem_n alone qualifies nothing.
- R3: In split-enable style a chip select (hst_cs_io_n or hst_cs_mem_n) must be low. Then hst_oe_n low requests a read and hst_we_n low requests a write. With both enables high nothing happens.
- R4: A read with hst_half=0 makes one memory read and returns bits [15:0] of the host-order word. A read with hst_half=1 returns bits [31:16] of the latched word and makes no memory request.
- R5: A write with hst_half=0 stages the data and makes no memory request. A write with hst_half=1 makes one memory write of {half-1 data, staged half-0 data} to the address given with the half-1 access.
- R6: With swap_en=0 the host-order word equals the memory word. With swap_en=1 the bytes of the 32-bit word are reversed (memory byte 3 becomes host byte 0). This holds for both reads and writes.
- R7: In modes 3'b000 and 3'b010, hst_wait and hst_wait_oe are both high while a memory request is outstanding. In mode 3'b001, hst_wait_oe stays low. When wait is not asserted, hst_wait_oe is low.
- R8: hst_dout_oe is high only in a qualified read once data is ready. It falls one core cycle after the synchronised strobe deasserts.
- R9: hst_irq equals irq_pend delayed by one core cycle, and it has no output enable.
- R10: In reset, hst_dout_oe, hst_wait_oe, mem_req and hst_irq are all low.
- R11: mem_req, mem_addr and mem_we stay unchanged until mem_ack, and each committing access makes exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Bus style strap |
| swap_en | input | 1 | Byte-order reversal enable |
| hst_cs_io_n | input | 1 | Register chip select, active low |
| hst_cs_mem_n | input | 1 | Memory chip select, active low |
| hst_strb_n | input | 1 | Access strobe, strobe style |
| hst_rnw | input | 1 | 1 read, 0 write, strobe style |
| hst_oe_n | input | 1 | Read enable, split-enable style |
| hst_we_n | input | 1 | Write enable, split-enable style |
| hst_addr | input | ADDR_W | Word address (bus bits 2 upward) |
| hst_half | input | 1 | Half-word select, 0 first |
| hst_din | input | 16 | Host write data |
| hst_dout | output | 16 | Host read data |
| hst_dout_oe | output | 1 | Data bus drive enable |
| hst_wait | output | 1 | Wait level, active high |
| hst_wait_oe | output | 1 | Wait drive enable |
| hst_irq | output | 1 | Interrupt, push-pull |
| irq_pend | input | 1 | Internal pending interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read word |

## Verification
A table of words is written as two halves and read back under all three valid modes, with both byte orders, through both chip selects, and at the lowest and highest addresses. After each write the bench inspects its memory model directly. This separates a correct byte reversal from one that is applied twice or not at all, because a read-back alone would hide both errors. After every access the bench counts memory handshakes, which tells a latched half-1 read or a staged half-0 write apart from one that wrongly goes to memory. Directed cases then try strobes without the right chip select, an undefined mode, enables with no chip select, an unwritten word read with reversal, zero memory latency and interrupt tracking.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HB_HALF_W = 16;
    localparam int HB_WORD_W = 2 * HB_HALF_W;
    localparam int HB_BYTES  = HB_WORD_W / 8;
    localparam int HB_MODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_SERVE,
        ST_HOLD
    } hb_state_e;

    typedef enum logic [1:0] {
        STY_NONE,
        STY_STRB,
        STY_SPLIT
    } hb_style_e;

    // Map the mode strap onto a bus style
    function automatic hb_style_e style_of(input logic [HB_MODE_W-1:0] m);
        hb_style_e s;
        case (m)
            3'b000:  s = STY_STRB;
            3'b001:  s = STY_STRB;
            3'b010:  s = STY_SPLIT;
            default: s = STY_NONE;
        endcase
        return s;
    endfunction

    function automatic logic wait_used(input logic [HB_MODE_W-1:0] m);
        return (m == 3'b000) || (m == 3'b010);
    endfunction

    // Reverse byte order of a full word
    function automatic logic [HB_WORD_W-1:0] byte_rev(input logic [HB_WORD_W-1:0] w);
        logic [HB_WORD_W-1:0] r;
        for (int i = 0; i < HB_BYTES; i++) begin
            r[8*i +: 8] = w[8*(HB_BYTES-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= RST_VAL;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
(
    input  logic [HB_MODE_W-1:0] mode,
    input  logic                 cs_io_n_s,
    input  logic                 cs_mem_n_s,
    input  logic                 strb_n_s,
    input  logic                 rnw_s,
    input  logic                 oe_n_s,
    input  logic                 we_n_s,
    output logic                 act,
    output logic                 is_rd
);

    hb_style_e style;
    logic      any_cs;

    assign style  = style_of(mode);
    assign any_cs = !cs_io_n_s || !cs_mem_n_s;

    always_comb begin
        act   = 1'b0;
        is_rd = 1'b0;
        unique case (style)
            STY_STRB: begin
                // strobe style: strobe and register select together
                act   = !strb_n_s && !cs_io_n_s;
                is_rd = rnw_s;
            end
            STY_SPLIT: begin
                act   = any_cs && (!oe_n_s || !we_n_s);
                is_rd = !oe_n_s;
            end
            STY_NONE: begin
                act   = 1'b0;
                is_rd = 1'b0;
            end
            default: begin
                act   = 1'b0;
                is_rd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hbus_steer.sv
module hbus_steer
    import hbus_pkg::*;
(
    input  logic                 swap_en,
    input  logic                 half_sel,
    input  logic [HB_WORD_W-1:0] rd_word,
    input  logic [HB_HALF_W-1:0] stage_lo,
    input  logic [HB_HALF_W-1:0] wr_hi,
    output logic [HB_HALF_W-1:0] dout,
    output logic [HB_WORD_W-1:0] wword
);

    logic [HB_WORD_W-1:0] host_rd;
    logic [HB_WORD_W-1:0] host_wr;

    assign host_rd = swap_en ? byte_rev(rd_word) : rd_word;
    assign dout    = half_sel ? host_rd[HB_WORD_W-1:HB_HALF_W] : host_rd[HB_HALF_W-1:0];
    assign host_wr = {wr_hi, stage_lo};
    assign wword   = swap_en ? byte_rev(host_wr) : host_wr;

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int SYNC_STGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode,
    input  logic                 swap_en,
    input  logic                 hst_cs_io_n,
    input  logic                 hst_cs_mem_n,
    input  logic                 hst_strb_n,
    input  logic                 hst_rnw,
    input  logic                 hst_oe_n,
    input  logic                 hst_we_n,
    input  logic [ADDR_W-1:0]    hst_addr,
    input  logic                 hst_half,
    input  logic [15:0]          hst_din,
    output logic [15:0]          hst_dout,
    output logic                 hst_dout_oe,
    output logic                 hst_wait,
    output logic                 hst_wait_oe,
    output logic                 hst_irq,
    input  logic                 irq_pend,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata
);

    localparam int NCTL = 6;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic            cs_io_n_s, cs_mem_n_s, strb_n_s, rnw_s, oe_n_s, we_n_s;
    logic            act_s, rd_s, act_d, start;

    hb_state_e       state, state_nx;
    logic [ADDR_W-1:0]    addr_q;
    logic                 half_q;
    logic [HB_WORD_W-1:0] rd_word_q;
    logic [HB_HALF_W-1:0] stage_lo_q, wr_hi_q;
    logic                 irq_q;
    logic [HB_WORD_W-1:0] wword;
    logic [HB_HALF_W-1:0] dout;
    logic                 mode_ok;

    assign ctl_raw = {hst_cs_io_n, hst_cs_mem_n, hst_strb_n, hst_rnw, hst_oe_n, hst_we_n};

    hbus_sync #(
        .W       (NCTL),
        .STAGES  (SYNC_STGS),
        .RST_VAL ({NCTL{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    assign {cs_io_n_s, cs_mem_n_s, strb_n_s, rnw_s, oe_n_s, we_n_s} = ctl_s;

    hbus_decode u_dec (
        .mode       (mode),
        .cs_io_n_s  (cs_io_n_s),
        .cs_mem_n_s (cs_mem_n_s),
        .strb_n_s   (strb_n_s),
        .rnw_s      (rnw_s),
        .oe_n_s     (oe_n_s),
        .we_n_s     (we_n_s),
        .act        (act_s),
        .is_rd      (rd_s)
    );

    hbus_steer u_steer (
        .swap_en  (swap_en),
        .half_sel (half_q),
        .rd_word  (rd_word_q),
        .stage_lo (stage_lo_q),
        .wr_hi    (wr_hi_q),
        .dout     (dout),
        .wword    (wword)
    );

    assign start   = act_s && !act_d;
    assign mode_ok = (style_of(mode) != STY_NONE);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (rd_s) state_nx = hst_half ? ST_SERVE : ST_FETCH;
                    else      state_nx = hst_half ? ST_WRITE : ST_HOLD;
                end
            end
            ST_FETCH: if (mem_ack) state_nx = ST_SERVE;
            ST_WRITE: if (mem_ack) state_nx = ST_HOLD;
            ST_SERVE: if (!act_s)  state_nx = ST_IDLE;
            ST_HOLD:  if (!act_s)  state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_d      <= 1'b0;
            addr_q     <= '0;
            half_q     <= 1'b0;
            rd_word_q  <= '0;
            stage_lo_q <= '0;
            wr_hi_q    <= '0;
            irq_q      <= 1'b0;
        end else begin
            act_d <= act_s;
            irq_q <= irq_pend;
            if (state == ST_IDLE && start) begin
                addr_q <= hst_addr;
                half_q <= hst_half;
                if (!rd_s) begin
                    if (hst_half) wr_hi_q    <= hst_din;
                    else          stage_lo_q <= hst_din;
                end
            end
            if (state == ST_FETCH && mem_ack) begin
                rd_word_q <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req     = (state == ST_FETCH) || (state == ST_WRITE);
        mem_we      = (state == ST_WRITE);
        mem_addr    = addr_q;
        mem_wdata   = wword;
        hst_dout_oe = (state == ST_SERVE);
        hst_dout    = dout;
        hst_wait    = mem_req && wait_used(mode);
        hst_wait_oe = mem_req && wait_used(mode);
        hst_irq     = irq_q;
    end

    // R11: request and its address and direction held until acknowledge
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R7: mode without wait never enables the wait pin
    assert_nowait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001) |-> !hst_wait_oe);

    // R8: data bus driven only while the synchronised read is qualified or just released
    assert_dout_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hst_dout_oe |-> (act_s || $past(act_s)));

    // R1: undefined mode produces no memory traffic and no bus drive
    assert_badmode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> (!mem_req && !hst_dout_oe));

    // R9: interrupt output tracks the pending input one cycle later
    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hst_irq == $past(irq_pend)));

endmodule

// File: tb/hbus_slave_tb.sv
module hbus_slave_tb_top;

    localparam int AW = 9;
    localparam int NV = 6;

    // {mode[45:43], swap[42], use_mem_cs[41], addr[40:32], word[31:0]}
    localparam logic [45:0] VECS [0:NV-1] = '{
        {3'b000, 1'b0, 1'b0, 9'd0,   32'h1234_5678},
        {3'b001, 1'b0, 1'b0, 9'd511, 32'hDEAD_BEEF},
        {3'b010, 1'b0, 1'b0, 9'd33,  32'h0F1E_2D3C},
        {3'b010, 1'b1, 1'b1, 9'd100, 32'hA1B2_C3D4},
        {3'b000, 1'b1, 1'b0, 9'd257, 32'h8000_0001},
        {3'b001, 1'b1, 1'b0, 9'd2,   32'hFFFF_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'b000;
    logic          swap_en = 1'b0;
    logic          hst_cs_io_n = 1'b1, hst_cs_mem_n = 1'b1, hst_strb_n = 1'b1;
    logic          hst_rnw = 1'b1, hst_oe_n = 1'b1, hst_we_n = 1'b1;
    logic [AW-1:0] hst_addr = '0;
    logic          hst_half = 1'b0;
    logic [15:0]   hst_din = '0;
    logic [15:0]   hst_dout;
    logic          hst_dout_oe, hst_wait, hst_wait_oe, hst_irq;
    logic          irq_pend = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 3;
    int lat_cnt = 0;
    int ops = 0;
    logic [31:0]    mem [512];
    logic [511:0]   vld = '0;

    always #10 clk = ~clk;

    hbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .swap_en(swap_en),
        .hst_cs_io_n(hst_cs_io_n), .hst_cs_mem_n(hst_cs_mem_n),
        .hst_strb_n(hst_strb_n), .hst_rnw(hst_rnw), .hst_oe_n(hst_oe_n),
        .hst_we_n(hst_we_n), .hst_addr(hst_addr), .hst_half(hst_half),
        .hst_din(hst_din), .hst_dout(hst_dout), .hst_dout_oe(hst_dout_oe),
        .hst_wait(hst_wait), .hst_wait_oe(hst_wait_oe), .hst_irq(hst_irq),
        .irq_pend(irq_pend), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] dflt(input logic [AW-1:0] a);
        return {~a[7:0], a[7:0], 8'h5A, 8'hC3};
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] peek(input logic [AW-1:0] a);
        return vld[a] ? mem[a] : dflt(a);
    endfunction

    // Memory model with adjustable latency
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= lat) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                ops     <= ops + 1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    vld[mem_addr] <= 1'b1;
                end else begin
                    mem_rdata <= peek(mem_addr);
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // csel: 0 register select, 1 memory select, 2 none
    task automatic access(input int csel, input bit rd, input bit hf, input logic [AW-1:0] a,
                          input logic [15:0] wd, output logic [15:0] rdv,
                          output bit saw_wait, output bit saw_oe);
        rdv = '0; saw_wait = 0; saw_oe = 0;
        hst_addr = a; hst_half = hf; hst_din = wd;
        hst_cs_io_n  = (csel != 0);
        hst_cs_mem_n = (csel != 1);
        if (mode == 3'b010) begin
            hst_oe_n = !rd;
            hst_we_n = rd;
        end else begin
            hst_rnw    = rd;
            hst_strb_n = 1'b0;
        end
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            if (hst_wait && hst_wait_oe) saw_wait = 1;
            if (hst_dout_oe) begin
                saw_oe = 1;
                rdv = hst_dout;
            end
        end
        hst_strb_n = 1'b1; hst_oe_n = 1'b1; hst_we_n = 1'b1;
        hst_cs_io_n = 1'b1; hst_cs_mem_n = 1'b1; hst_rnw = 1'b1;
        repeat (5) @(negedge clk);
        chk(hst_dout_oe == 1'b0, "R8 bus released after strobe", {31'b0, hst_dout_oe}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        bit sw_w, so;
        int o0;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!hst_dout_oe && !hst_wait_oe && !mem_req && !hst_irq, "R10 reset outputs",
            {28'b0, hst_dout_oe, hst_wait_oe, mem_req, hst_irq}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            logic [AW-1:0] a;
            int cs;
            bit waits;
            w = VECS[v][31:0];
            a = VECS[v][40:32];
            cs = VECS[v][41] ? 1 : 0;
            mode = VECS[v][45:43];
            swap_en = VECS[v][42];
            waits = (mode != 3'b001);
            lat = 3;
            o0 = ops;
            access(cs, 0, 0, a, w[15:0], rv, sw_w, so);
            chk(ops == o0, "R5 half-0 write stages only", ops, o0);
            access(cs, 0, 1, a, w[31:16], rv, sw_w, so);
            chk(ops == o0 + 1, "R5 R11 one commit write", ops, o0 + 1);
            chk(sw_w == waits, "R7 wait on write", {31'b0, sw_w}, {31'b0, waits});
            chk(mem[a] == (swap_en ? rev(w) : w), "R6 R5 stored word order", mem[a],
                swap_en ? rev(w) : w);
            access(cs, 1, 0, a, 16'h0, rv, sw_w, so);
            chk(so && rv == w[15:0], "R4 R2 R3 low half read", {15'b0, so, rv}, {16'h1, w[15:0]});
            chk(ops == o0 + 2, "R4 half-0 read fetches once", ops, o0 + 2);
            chk(sw_w == waits, "R7 wait on read", {31'b0, sw_w}, {31'b0, waits});
            access(cs, 1, 1, a, 16'h0, rv, sw_w, so);
            chk(so && rv == w[31:16], "R4 high half from latch", {15'b0, so, rv}, {16'h1, w[31:16]});
            chk(ops == o0 + 2, "R4 half-1 read no request", ops, o0 + 2);
        end

        // R6 unwritten word read with reversal, split style, zero latency (R11)
        mode = 3'b010; swap_en = 1'b1; lat = 0; o0 = ops;
        access(0, 1, 0, 9'd7, 16'h0, rv, sw_w, so);
        chk(so && rv == rev(dflt(9'd7))[15:0], "R6 reversed read of preset word",
            {16'b0, rv}, {16'b0, rev(dflt(9'd7))[15:0]});
        chk(ops == o0 + 1, "R11 single request at zero latency", ops, o0 + 1);
        lat = 3;

        // R3 enables with no chip select
        o0 = ops;
        access(2, 1, 0, 9'd7, 16'h0, rv, sw_w, so);
        chk(ops == o0 && !so, "R3 no chip select ignored", {15'b0, so, 16'(ops - o0)}, 32'h0);

        // R2 strobe with only memory select
        mode = 3'b000; swap_en = 1'b0; o0 = ops;
        access(1, 1, 0, 9'd7, 16'h0, rv, sw_w, so);
        chk(ops == o0 && !so, "R2 memory select does not qualify strobe",
            {15'b0, so, 16'(ops - o0)}, 32'h0);

        // R1 undefined modes
        mode = 3'b110; o0 = ops;
        access(0, 1, 0, 9'd7, 16'h0, rv, sw_w, so);
        chk(ops == o0 && !so, "R1 mode 110 ignored", {15'b0, so, 16'(ops - o0)}, 32'h0);
        mode = 3'b011; o0 = ops;
        access(0, 0, 1, 9'd7, 16'h5555, rv, sw_w, so);
        chk(ops == o0 && !vld[7], "R1 mode 011 write ignored", 16'(ops - o0), 32'h0);
        mode = 3'b000;

        // R9 interrupt tracking
        irq_pend = 1'b1;
        @(negedge clk);
        chk(hst_irq == 1'b1, "R9 irq rises", {31'b0, hst_irq}, 32'h1);
        irq_pend = 1'b0;
        @(negedge clk);
        chk(hst_irq == 1'b0, "R9 irq falls", {31'b0, hst_irq}, 32'h0);

        finish_run();
    end

endmodule